// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block turns single read or write requests from a processor into cycles on an external memory bus. The low eight address bits and the eight data bits share one set of bus lines. The five upper address bits have their own lines, so the block reaches 8 KB of program space and 8 KB of data space. A select line picks between the two spaces. The block drives an active-low address strobe, an active-low data strobe, a read line and that space select. It drives the shared lines through an output enable, so the pad can float them.

Requests arrive on a valid/ready interface. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a cycle runs, `req_ready` stays low. The source must hold `req_valid` and every request field steady until the request is taken. Nothing is dropped, and a held request starts in the cycle after the current one ends.

`wait_cnt` is a plain control input and is sampled when a request is taken. Each wait state adds one cycle to the data strobe. Completion is a one-cycle `rsp_valid` pulse with no back-pressure, and for reads it carries the returned byte on `rsp_rdata`.

Top module: `xbus_ctrl`

## Requirements
- R1: During and right after reset: `as_n`=1, `ds_n`=1, `ad_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: The first cycle after a request is taken is the set-up cycle. In it:
  - `as_n`=1 and `ad_oe`=1;
  - `ad_out` carries address bits 7:0 and `hi_addr` carries address bits 12:8;
  - `bus_rd`=1 for a read and 0 for a write;
  - `dsel`=1 for data space and 0 for program space.
  
  `as_n` is low for exactly the second cycle, with the address still driven.
- R3: In the third cycle `as_n` is high again, and the address stays driven on the shared lines (`ad_oe`=1) as a hold.
- R4: `bus_rd`, `dsel` and `hi_addr` do not change from the set-up cycle through the cycle after the data strobe rises.
- R5: The fourth cycle is a turnaround with both strobes high. On a read the shared lines float (`ad_oe`=0). On a write they carry the write data.
- R6: `ds_n` falls in the fifth cycle. It stays low for 3+W cycles on a read or 2+W cycles on a write, where W is `wait_cnt` at acceptance.
- R7: On a read:
  - `ad_oe` stays 0 through the data phase;
  - `ad_in` is captured at the clock edge where `ds_n` rises;
  - in the cycle after that edge, `rsp_valid`=1 for one cycle with the byte on `rsp_rdata`.
- R8: On a write, `ad_out` carries the write data with `ad_oe`=1 through the data phase and for one cycle after `ds_n` rises. `rsp_valid` pulses in that cycle.
- R9: After `ds_n` rises, `as_n` stays high for at least two cycles. `req_ready` is high in the cycle after `ds_n` rises, so a held request starts in the next cycle.
- R10: `req_ready` is low from the set-up cycle through the last data-strobe cycle. A request held under back-pressure is neither lost nor duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dspace | input | 1 | 1 = data space, 0 = program space |
| wait_cnt | input | 3 | Wait states added to the data strobe |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read from the bus |
| ad_out | output | 8 | Shared address/data lines, outgoing |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 8 | Shared address/data lines, incoming |
| hi_addr | output | 5 | Address bits 12:8 |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| bus_rd | output | 1 | 1 = read cycle, 0 = write cycle |
| dsel | output | 1 | 1 = data space selected |

## Verification
The hardest situation to reach is a request that is already waiting when a cycle ends. It tests the hand-over in the recovery cycle, the gap between the data strobe rising and the next address strobe, and the rule that a held request runs exactly once. The bench holds `req_valid` high across a whole read cycle and then drops it right after the second acceptance. It checks the cycle of each address strobe and each completion pulse against positions computed from the wait count. A full sweep over every wait count, both directions and both spaces covers the two data-strobe widths, including the shortest ones.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ASTB, ST_HOLD, ST_TURN, ST_DATA, ST_RECOV
  } xbus_state_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int WAIT_W  = 3,
  parameter int RD_BASE = 3,
  parameter int WR_BASE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_dspace,
  input  logic [WAIT_W-1:0] wait_cnt,
  output logic              req_ready,
  output xbus_state_e       state,
  output logic              last_data,
  output logic [ADDR_W-1:0] q_addr,
  output logic [DATA_W-1:0] q_wdata,
  output logic              q_write,
  output logic              q_dspace
);
  localparam int MAXB  = (RD_BASE > WR_BASE) ? RD_BASE : WR_BASE;
  localparam int CNT_W = $clog2(MAXB + (1 << WAIT_W)) + 1;

  logic [WAIT_W-1:0] q_wait;
  logic [CNT_W-1:0]  cnt, span;
  logic              take;

  assign req_ready = (state == ST_IDLE) || (state == ST_RECOV);
  assign take      = req_valid && req_ready;
  assign last_data = (state == ST_DATA) && (cnt == '0);
  assign span      = (q_write ? CNT_W'(WR_BASE) : CNT_W'(RD_BASE))
                     + CNT_W'(q_wait) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      q_addr   <= '0;
      q_wdata  <= '0;
      q_write  <= 1'b0;
      q_dspace <= 1'b0;
      q_wait   <= '0;
    end else begin
      if (take) begin
        q_addr   <= req_addr;
        q_wdata  <= req_wdata;
        q_write  <= req_write;
        q_dspace <= req_dspace;
        q_wait   <= wait_cnt;
      end
      unique case (state)
        ST_IDLE:  if (take) state <= ST_SETUP;
        ST_SETUP: state <= ST_ASTB;
        ST_ASTB:  state <= ST_HOLD;
        ST_HOLD:  state <= ST_TURN;
        ST_TURN: begin
          state <= ST_DATA;
          cnt   <= span;
        end
        ST_DATA: begin
          if (cnt == '0) state <= ST_RECOV;
          else           cnt   <= cnt - CNT_W'(1);
        end
        ST_RECOV: state <= take ? ST_SETUP : ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_pads.sv
module xbus_pads
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LO_W   = 8
) (
  input  xbus_state_e       state,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic [LO_W-1:0]   q_wdata,
  input  logic              q_write,
  input  logic              q_dspace,
  output logic [LO_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-LO_W-1:0] hi_addr,
  output logic              as_n,
  output logic              ds_n,
  output logic              bus_rd,
  output logic              dsel
);
  logic addr_phase, data_side;

  assign addr_phase = (state == ST_SETUP) || (state == ST_ASTB) || (state == ST_HOLD);
  assign data_side  = (state == ST_TURN) || (state == ST_DATA) || (state == ST_RECOV);

  assign hi_addr = q_addr[ADDR_W-1:LO_W];
  assign bus_rd  = !q_write;
  assign dsel    = q_dspace;
  assign as_n    = (state != ST_ASTB);
  assign ds_n    = (state != ST_DATA);
  assign ad_oe   = addr_phase || (data_side && q_write);

  always_comb begin
    if (data_side && q_write) ad_out = q_wdata;
    else                      ad_out = q_addr[LO_W-1:0];
  end
endmodule

// File: rtl/xbus_rdcap.sv
module xbus_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= ad_in;
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int WAIT_W  = 3,
  parameter int RD_BASE = 3,
  parameter int WR_BASE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_write,
  input  logic                     req_dspace,
  input  logic [WAIT_W-1:0]        wait_cnt,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic                     as_n,
  output logic                     ds_n,
  output logic                     bus_rd,
  output logic                     dsel
);
  xbus_state_e       state;
  logic              last_data;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic              q_write, q_dspace;

  xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W),
             .RD_BASE(RD_BASE), .WR_BASE(WR_BASE)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_dspace(req_dspace),
    .wait_cnt(wait_cnt), .req_ready(req_ready), .state(state),
    .last_data(last_data), .q_addr(q_addr), .q_wdata(q_wdata),
    .q_write(q_write), .q_dspace(q_dspace)
  );

  xbus_pads #(.ADDR_W(ADDR_W), .LO_W(DATA_W)) u_pads (
    .state(state), .q_addr(q_addr), .q_wdata(q_wdata), .q_write(q_write),
    .q_dspace(q_dspace), .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr),
    .as_n(as_n), .ds_n(ds_n), .bus_rd(bus_rd), .dsel(dsel)
  );

  xbus_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk(clk), .rst_n(rst_n), .capture(last_data && !q_write),
    .ad_in(ad_in), .rdata(rsp_rdata)
  );

  assign rsp_valid = (state == ST_RECOV);
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              as_n,
  input logic              ds_n,
  input logic              ad_oe,
  input logic [DATA_W-1:0] ad_out,
  input logic [HI_W-1:0]   hi_addr,
  input logic              bus_rd,
  input logic              dsel,
  input logic              rsp_valid,
  input logic              req_ready
);
  // R1: the strobes rest high and the lines float while in reset
  always_comb if (!rst_n) assert_reset_idle_R1: assert (as_n && ds_n && !ad_oe);

  assert_as_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_n) |-> ad_oe && $past(ad_oe) && $stable(ad_out));

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_n) |-> ad_oe && $stable(ad_out) && ds_n);

  assert_ctl_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n || !as_n) |-> $stable(bus_rd) && $stable(dsel) && $stable(hi_addr));

  assert_strobes_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n) |-> $past(as_n) && $past(ds_n) && as_n);

  assert_rd_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && bus_rd) |-> !ad_oe);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_wr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ds_n) && !bus_rd) |-> ad_oe && $stable(ad_out));

  assert_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ds_n) |-> as_n && req_ready ##1 as_n);

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n || !ds_n) |-> !req_ready);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.DATA_W(DATA_W), .HI_W(ADDR_W-DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .ad_oe(ad_oe),
  .ad_out(ad_out), .hi_addr(hi_addr), .bus_rd(bus_rd), .dsel(dsel),
  .rsp_valid(rsp_valid), .req_ready(req_ready)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_dspace = 1'b0;
  logic [2:0]  wait_cnt = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata, ad_out, ad_in;
  logic        ad_oe, as_n, ds_n, bus_rd, dsel;
  logic [4:0]  hi_addr;
  logic [12:0] dev_addr = '0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_dspace(req_dspace), .wait_cnt(wait_cnt), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .hi_addr(hi_addr), .as_n(as_n), .ds_n(ds_n), .bus_rd(bus_rd), .dsel(dsel)
  );

  function automatic logic [7:0] mem_val(logic [12:0] a, logic d);
    return a[7:0] ^ {a[12:8], 3'b101} ^ (d ? 8'h3C : 8'h00);
  endfunction

  // device model: latches the address while the address strobe is low
  always @(posedge clk) if (!as_n) dev_addr <= {hi_addr, ad_out};
  assign ad_in = (!ds_n && bus_rd) ? mem_val(dev_addr, dsel) : 8'hEE;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_txn(logic [12:0] a, logic [7:0] wd, bit wr, bit ds, int w);
    int len;
    len = (wr ? 2 : 3) + w;
    @(negedge clk);
    req_addr = a; req_wdata = wd; req_write = wr; req_dspace = ds;
    wait_cnt = 3'(w); req_valid = 1'b1;
    chk(req_ready == 1'b1, "R10 ready when idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 1; n <= len + 6; n++) begin
      if (n > 1) @(negedge clk);
      if (n <= len + 5) begin
        chk(bus_rd == !wr && dsel == ds && hi_addr == a[12:8], "R4 control lines",
            {bus_rd, dsel, hi_addr}, {!wr, ds, a[12:8]});
      end
      if (n <= len + 4)
        chk(req_ready == 1'b0, "R10 busy", req_ready, 0);
      if (n == 1) begin
        chk(as_n && ad_oe && ad_out == a[7:0], "R2 setup", {as_n, ad_oe, ad_out}, {2'b11, a[7:0]});
      end else if (n == 2) begin
        chk(!as_n && ds_n && ad_oe && ad_out == a[7:0], "R2 strobe",
            {as_n, ds_n, ad_oe, ad_out}, {3'b011, a[7:0]});
      end else if (n == 3) begin
        chk(as_n && ad_oe && ad_out == a[7:0], "R3 hold", {as_n, ad_oe, ad_out}, {2'b11, a[7:0]});
      end else if (n == 4) begin
        chk(as_n && ds_n && ad_oe == wr, "R5 turnaround", {as_n, ds_n, ad_oe}, {2'b11, wr});
        if (wr) chk(ad_out == wd, "R5 write data", ad_out, wd);
      end else if (n <= len + 4) begin
        chk(ds_n == 1'b0 && as_n, "R6 data strobe low", {as_n, ds_n}, 2'b10);
        if (wr) chk(ad_oe && ad_out == wd, "R8 write drive", {ad_oe, ad_out}, {1'b1, wd});
        else    chk(!ad_oe, "R7 read float", ad_oe, 0);
        chk(!rsp_valid, "R7 no early done", rsp_valid, 0);
      end else if (n == len + 5) begin
        chk(ds_n && as_n, "R6 strobe width end", {as_n, ds_n}, 2'b11);
        chk(rsp_valid, "R7 done pulse", rsp_valid, 1);
        chk(req_ready, "R9 ready at recovery", req_ready, 1);
        if (wr) chk(ad_oe && ad_out == wd, "R8 write hold", {ad_oe, ad_out}, {1'b1, wd});
        else    chk(rsp_rdata == mem_val(a, ds), "R7 read data", rsp_rdata, mem_val(a, ds));
      end else begin
        chk(!rsp_valid && as_n && ds_n && !ad_oe, "R9 idle after",
            {rsp_valid, as_n, ds_n, ad_oe}, 4'b0110);
      end
    end
  endtask

  initial begin
    logic [12:0] addrs [3];
    addrs[0] = 13'h0000; addrs[1] = 13'h1FFF; addrs[2] = 13'h0A5C;
    repeat (3) @(negedge clk);
    chk(as_n && ds_n && !ad_oe && req_ready && !rsp_valid, "R1 in reset",
        {as_n, ds_n, ad_oe, req_ready, rsp_valid}, 5'b11010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(as_n && ds_n && !ad_oe && req_ready && !rsp_valid, "R1 after reset",
        {as_n, ds_n, ad_oe, req_ready, rsp_valid}, 5'b11010);
    for (int w = 0; w < 8; w++)
      for (int k = 0; k < 8; k++)
        for (int ai = 0; ai < 3; ai++)
          if (k < 4)
            run_txn(addrs[ai] ^ 13'(w * 37), 8'(8'h5A + w * 19 + ai), k[0], k[1], w);
    // R9 / R10: request held under back-pressure runs once more, right after recovery
    @(negedge clk);
    req_addr = 13'h1234; req_write = 1'b0; req_dspace = 1'b1; wait_cnt = 3'd1;
    req_valid = 1'b1;
    for (int n = 0; n <= 20; n++) begin
      if (n > 0) @(negedge clk);
      if (n == 10) req_valid = 1'b0;
      if (n >= 1) begin
        chk(as_n == !(n == 2 || n == 11), "R9 next address strobe", as_n, !(n == 2 || n == 11));
        chk(rsp_valid == (n == 9 || n == 18), "R10 held request done once",
            rsp_valid, (n == 9 || n == 18));
      end
      if (n == 9) chk(req_ready, "R9 ready in recovery", req_ready, 1);
      if (n == 18) chk(rsp_rdata == mem_val(13'h1234, 1'b1), "R7 chained read",
                       rsp_rdata, mem_val(13'h1234, 1'b1));
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule